// File: doc/BRIEF.md
# Capture/Compare Channel Status Flags

This block holds three general registers, one per channel (A, B, C), that all work against one shared free-running counter value supplied from outside. Each channel is set by its own mode select to work either as an input-capture register, where an external strobe copies the counter into the register, or as an output-compare register, where equality between the counter and the register is detected. A capture or a compare match raises that channel's status flag. The flag vector goes straight to the interrupt logic, and it can also be read over a simple register bus.

A flag can only be cleared through a two-step handshake. Software must first read the status register and see the flag as 1. It then writes 0 to that bit. A write of 0 without that read has no effect, and a write of 1 never has any effect. When a new set event lands in the same cycle as an accepted clear, the set wins, so no event is lost. Compare matches are only detected when the counter changes value. A counter that stops on the matching value therefore does not set the flag again after it has been cleared.

Top module: `capcmp_flags`

## Requirements
- R1: Address 0 is the status register, with flag A in bit 0, B in bit 1, C in bit 2 and all higher bits reading 0. `flag_out` carries the same three bits in the same order. Addresses 1, 2 and 3 are the general registers of A, B and C, readable and writable. Read data appears on `bus_rdata` in the cycle after the one in which `bus_rd` is high, and it holds until the next read.
- R2: After reset all flags are 0, every general register is 0 and `bus_rdata` is 0.
- R3: With `mode_cmp[i]`=0 (capture), a high `cap_strobe[i]` copies `cnt_val` into general register i and sets flag i, both visible in the next cycle.
- R4: With `mode_cmp[i]`=1 (compare), flag i is set in the cycle after a cycle in which `cnt_val` differs from its value in the previous cycle and equals general register i.
- R5: Writing 0 to a status bit clears that flag only if a status read since the flag was last set returned the bit as 1. Without such a read, the write leaves the flag at 1.
- R6: Writing 1 to a status bit changes neither the flag nor whether it is armed for clearing.
- R7: If a set event for channel i occurs in the same cycle as an armed write of 0 to bit i, flag i is 1 afterwards.
- R8: While `cnt_val` holds at the value of a compare-mode register, no new set event occurs, even after the flag is cleared. A bus write that makes the register equal to the held counter also raises no event.
- R9: In compare mode, `cap_strobe[i]` is ignored: neither flag i nor general register i changes.
- R10: Any write of 0 to a status bit uses up that bit's arming, even when a simultaneous set keeps the flag at 1. A further clear then needs a new read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address (0 status, 1..3 general registers) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| cap_strobe | input | 3 | Per-channel capture strobes (bit 0 = A) |
| mode_cmp | input | 3 | Per-channel mode: 1 compare, 0 capture |
| cnt_val | input | CNT_W | Shared counter value |
| flag_out | output | 3 | Status flags to interrupt logic (bit 0 = A) |

## Verification
The case hardest to reach from the ports is a set event that coincides exactly with an armed clear. The bench first reads the status register to arm the bit, and then raises the set event and the write of 0 in the same cycle. In capture mode the set event is a capture strobe. In compare mode the counter is moved off the compare value and then stepped back onto it. The bench then checks that the arming has been used up. For compare mode, every channel is swept through all 256 counter values of an 8-bit counter, starting just past the register value. The flag must rise only on the single step that reaches the match. A held counter and a register rewritten to the held value are then shown to raise no event.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
    localparam int NCH         = 3;
    localparam int ADDR_STATUS = 0;
    localparam int ADDR_GR0    = 1;
endpackage

// File: rtl/capcmp_channel.sv
module capcmp_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_cmp,
    input  logic             cap,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_chg,
    input  logic             gr_we,
    input  logic [CNT_W-1:0] gr_wdata,
    input  logic             st_rd,
    input  logic             st_wr,
    input  logic             st_wbit,
    output logic             flag,
    output logic [CNT_W-1:0] gr
);
    typedef struct packed {
        logic [CNT_W-1:0] gr;
        logic             flag;
        logic             arm;
    } ch_state_t;

    ch_state_t s_d, s_q;
    logic      cap_ev, cmp_ev, set_ev, wr_zero;

    always_comb begin
        cap_ev  = cap && !mode_cmp;
        cmp_ev  = mode_cmp && cnt_chg && (cnt_val == s_q.gr);
        set_ev  = cap_ev || cmp_ev;
        wr_zero = st_wr && !st_wbit;
        s_d     = s_q;
        if (cap_ev) begin
            s_d.gr = cnt_val;
        end else if (gr_we) begin
            s_d.gr = gr_wdata;
        end
        if (set_ev) begin
            s_d.flag = 1'b1;
        end else if (wr_zero && s_q.arm) begin
            s_d.flag = 1'b0;
        end
        if (st_rd && s_q.flag) begin
            s_d.arm = 1'b1;
        end else if (wr_zero) begin
            s_d.arm = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flag = s_q.flag;
    assign gr   = s_q.gr;
endmodule

// File: rtl/capcmp_bus.sv
module capcmp_bus
    import capcmp_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [NCH-1:0]       flags,
    input  logic [NCH*CNT_W-1:0] gr_all,
    output logic                 st_rd,
    output logic                 st_wr,
    output logic [NCH-1:0]       gr_we,
    output logic [CNT_W-1:0]     bus_rdata
);
    typedef struct packed {
        logic [CNT_W-1:0] rdata;
    } bus_state_t;

    bus_state_t s_d, s_q;
    logic       sel_st;

    always_comb begin
        sel_st = (bus_addr == ADDR_W'(ADDR_STATUS));
        st_rd  = bus_rd && sel_st;
        st_wr  = bus_wr && sel_st;
        for (int i = 0; i < NCH; i++) begin
            gr_we[i] = bus_wr && (bus_addr == ADDR_W'(ADDR_GR0 + i));
        end
        s_d = s_q;
        if (bus_rd) begin
            s_d.rdata = '0;
            if (sel_st) begin
                s_d.rdata[NCH-1:0] = flags;
            end
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == ADDR_W'(ADDR_GR0 + i)) begin
                    s_d.rdata = gr_all[i*CNT_W +: CNT_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;
endmodule

// File: rtl/capcmp_flags.sv
module capcmp_flags
    import capcmp_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [2:0]        cap_strobe,
    input  logic [2:0]        mode_cmp,
    input  logic [CNT_W-1:0]  cnt_val,
    output logic [2:0]        flag_out
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt_prev;
    } top_state_t;

    top_state_t           s_d, s_q;
    logic                 cnt_chg;
    logic                 st_rd, st_wr;
    logic [NCH-1:0]       gr_we;
    logic [NCH-1:0]       flags;
    logic [NCH*CNT_W-1:0] gr_all;

    always_comb begin
        s_d          = s_q;
        s_d.cnt_prev = cnt_val;
        cnt_chg      = (cnt_val != s_q.cnt_prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    capcmp_bus #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .flags     (flags),
        .gr_all    (gr_all),
        .st_rd     (st_rd),
        .st_wr     (st_wr),
        .gr_we     (gr_we),
        .bus_rdata (bus_rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        capcmp_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_cmp (mode_cmp[i]),
            .cap      (cap_strobe[i]),
            .cnt_val  (cnt_val),
            .cnt_chg  (cnt_chg),
            .gr_we    (gr_we[i]),
            .gr_wdata (bus_wdata),
            .st_rd    (st_rd),
            .st_wr    (st_wr),
            .st_wbit  (bus_wdata[i]),
            .flag     (flags[i]),
            .gr       (gr_all[i*CNT_W +: CNT_W])
        );
    end

    assign flag_out = flags;
endmodule

// File: rtl/capcmp_flags_chk.sv
module capcmp_flags_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic [2:0]        cap_strobe,
    input logic [2:0]        mode_cmp,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [2:0]        flag_out,
    input logic [3*CNT_W-1:0] gr_all
);
    logic [CNT_W-1:0] seen_q;
    logic             st_wr_ev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else begin
            seen_q <= cnt_val;
        end
    end

    assign st_wr_ev = bus_wr && (bus_addr == '0);

    for (genvar i = 0; i < 3; i++) begin : g_a
        logic [CNT_W-1:0] gr_i;
        logic             set_i;
        assign gr_i  = gr_all[i*CNT_W +: CNT_W];
        assign set_i = (cap_strobe[i] && !mode_cmp[i]) ||
                       (mode_cmp[i] && cnt_val != seen_q && cnt_val == gr_i);

        a_r3_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_strobe[i] && !mode_cmp[i]) |=> (flag_out[i] && gr_i == $past(cnt_val)));

        a_r4_compare_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_cmp[i] && cnt_val != seen_q && cnt_val == gr_i) |=> flag_out[i]);

        a_r5_clear_needs_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_out[i] && !(st_wr_ev && !bus_wdata[i])) |=> flag_out[i]);

        a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i && st_wr_ev && !bus_wdata[i]) |=> flag_out[i]);

        a_r9_capture_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_strobe[i] && mode_cmp[i] &&
             !(bus_wr && bus_addr == ADDR_W'(i + 1))) |=> (gr_i == $past(gr_i)));
    end
endmodule

bind capcmp_flags capcmp_flags_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .cap_strobe (cap_strobe),
    .mode_cmp   (mode_cmp),
    .cnt_val    (cnt_val),
    .flag_out   (flag_out),
    .gr_all     (gr_all)
);

// File: tb/capcmp_flags_tb.sv
`timescale 1ns/1ps
module capcmp_flags_tb;
    localparam int W  = 8;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0, bus_wr = 1'b0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [2:0]    cap_strobe = '0, mode_cmp = '0;
    logic [W-1:0]  cnt_val = '0;
    logic [2:0]    flag_out;

    int n_tests = 0, n_fail = 0;
    logic [W-1:0] rd;

    always #2.5 clk = ~clk;

    capcmp_flags #(.CNT_W(W), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_strobe(cap_strobe), .mode_cmp(mode_cmp), .cnt_val(cnt_val),
        .flag_out(flag_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [W-1:0] d);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rdreg(input int a, output logic [W-1:0] d);
        bus_addr = AW'(a); bus_rd = 1'b1;
        tick();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic clear_all();
        logic [W-1:0] t;
        rdreg(0, t);
        wr(0, '0);
    endtask

    initial begin
        #900000;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check("R2 flags after reset", flag_out, 0);
        check("R2 rdata after reset", bus_rdata, 0);
        for (int i = 1; i <= 3; i++) begin
            rdreg(i, rd);
            check("R2 general register after reset", rd, 0);
        end
        rdreg(0, rd);
        check("R2 status after reset", rd, 0);

        // R3 capture sweep, R1 bit positions
        mode_cmp = 3'b000;
        for (int ch = 0; ch < 3; ch++) begin
            for (int v = 0; v < 256; v += 37) begin
                cnt_val = W'(v + ch);
                cap_strobe[ch] = 1'b1;
                tick();
                cap_strobe = '0;
                check("R3 capture sets only own flag", flag_out, 32'(1 << ch));
                rdreg(ch + 1, rd);
                check("R3 captured counter value", rd, (v + ch) & 255);
                rdreg(0, rd);
                check("R1 status bit position", rd, 32'(1 << ch));
                wr(0, '0);
                check("R5 clear after read", flag_out, 0);
            end
        end

        // R5 clear without read ignored; R6 write 1 no effect
        cap_strobe = 3'b111; tick(); cap_strobe = '0;
        check("R3 all three captured", flag_out, 3'b111);
        wr(0, '0);
        check("R5 write0 without read ignored", flag_out, 3'b111);
        rdreg(0, rd);
        check("R1 status reads all flags", rd, 3'b111);
        wr(0, 8'hFF);
        check("R6 write1 keeps flags", flag_out, 3'b111);
        wr(0, 8'b1111_1010);
        check("R6 arming kept after write1, bits0,2 cleared", flag_out, 3'b010);
        wr(0, '0);
        check("R5 bit1 armed, now cleared", flag_out, 0);

        // R4 compare sweep over every counter value per channel
        for (int ch = 0; ch < 3; ch++) begin
            for (int k = 0; k < 3; k++) begin
                int v; int bad;
                v = (k * 91 + ch * 17 + 5) & 255;
                mode_cmp = 3'(1 << ch);
                cnt_val = W'(v + 1);
                wr(ch + 1, W'(v));
                tick();
                clear_all();
                bad = 0;
                for (int j = 1; j < 256; j++) begin
                    cnt_val = W'(v + 1 + j);
                    tick();
                    if (flag_out !== 3'(((j == 255) ? 1 : 0) << ch)) bad++;
                end
                check("R4 compare sweep mismatching steps", bad, 0);
                clear_all();
            end
        end

        // R8 held counter, and register write to held value
        mode_cmp = 3'b001;
        cnt_val = 8'h3F; wr(1, 8'h40); tick(); clear_all();
        cnt_val = 8'h40; tick();
        check("R4 match flag A", flag_out, 3'b001);
        clear_all();
        repeat (5) tick();
        check("R8 held counter no re-set", flag_out, 0);
        mode_cmp = 3'b010;
        wr(2, 8'h40); repeat (3) tick();
        check("R8 register write to held value no event", flag_out, 0);

        // R9 capture ignored in compare mode
        cnt_val = 8'h77; tick();
        cap_strobe = 3'b010; tick(); cap_strobe = '0;
        check("R9 capture in compare mode no flag", flag_out, 0);
        rdreg(2, rd);
        check("R9 capture in compare mode register kept", rd, 8'h40);

        // R7 set wins in capture mode; R10 arming consumed
        mode_cmp = 3'b000;
        cap_strobe = 3'b010; tick(); cap_strobe = '0;
        rdreg(0, rd);
        bus_addr = '0; bus_wdata = '0; bus_wr = 1'b1; cap_strobe = 3'b010;
        tick();
        bus_wr = 1'b0; cap_strobe = '0;
        check("R7 capture set wins over clear", flag_out, 3'b010);
        wr(0, '0);
        check("R10 arming consumed, write0 ignored", flag_out, 3'b010);
        clear_all();
        check("R5 clear after fresh read", flag_out, 0);

        // R7 set wins in compare mode
        mode_cmp = 3'b100;
        cnt_val = 8'h0F; wr(3, 8'h10); tick();
        cnt_val = 8'h10; tick();
        check("R4 compare flag C", flag_out, 3'b100);
        cnt_val = 8'h0F; tick();
        rdreg(0, rd);
        check("R1 flag C at bit 2", rd, 3'b100);
        bus_addr = '0; bus_wdata = '0; bus_wr = 1'b1; cnt_val = 8'h10;
        tick();
        bus_wr = 1'b0;
        check("R7 compare set wins over clear", flag_out, 3'b100);
        wr(0, '0);
        check("R10 compare arming consumed", flag_out, 3'b100);
        clear_all();
        check("R5 compare flag cleared after read", flag_out, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule